// File: doc/BRIEF.md
# Prefetch Read Buffer

This block holds four entries that software fills ahead of time, so that later loads are served without waiting on memory. A prefetch command names one entry, a word address and a length code for 1, 4 or 8 consecutive words. The command is taken in a single cycle and never back-pressured. The buffer then issues one-word reads on a simple memory port and fills the entry in the background.

Every load address is compared against all entries in the same cycle. A word that has arrived is returned as a hit. The buffer's answer takes priority over any copy of that word held in the data cache. A word that is covered but still on its way raises a wait indication until it arrives.

A new prefetch removes every word it covers from the other entries, so each word is held by at most one entry. A prefetch to an entry that is still filling discards the old fill and starts the new one. Stores never reach the buffer, so keeping it coherent with stores is left to software.

Top module: `pf_read_buf`

## Requirements
- R1: After reset no entry holds a word: loads give ld_hit=0 and ld_wait=0, and mem_req is 0.
- R2: pf_slot selects entry 0 to 3. pf_len 0 covers 1 word, 1 covers 4 words and 2 covers 8 words, counted upward from pf_addr (a word address). The word just past the range misses.
- R3: A command with pf_len=3 has no effect on any entry.
- R4: Fills are one word per request. mem_addr is held stable with mem_req high until mem_ack. mem_rdata is captured in the cycle mem_ack is high.
- R5: A load to a covered word that has arrived gives ld_hit=1, with ld_data equal to the value memory returned for that word.
- R6: A load to a covered word that has not yet arrived gives ld_wait=1 and ld_hit=0. It turns into a hit once the word arrives. ld_hit and ld_wait are never both high.
- R7: A load to a word that no entry covers, or any cycle with ld_valid=0, gives ld_hit=0, ld_wait=0 and ld_data=0.
- R8: A prefetch clears the words it covers from every other entry, so a load to such a word returns the newly fetched value.
- R9: A prefetch into an entry that is still filling cancels the old range. Words of the old range then miss and the new range fills.
- R10: Changes to memory contents after a word has been buffered do not alter the buffered value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pf_valid | input | 1 | Prefetch command strobe |
| pf_slot | input | 2 | Target entry |
| pf_addr | input | AW | First word address |
| pf_len | input | 2 | Length code (0:1, 1:4, 2:8, 3:ignored) |
| ld_valid | input | 1 | Load lookup strobe |
| ld_addr | input | AW | Load word address |
| ld_hit | output | 1 | Word returned from buffer |
| ld_wait | output | 1 | Word covered but still pending |
| ld_data | output | DW | Returned word, zero unless hit |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read word address |
| mem_ack | input | 1 | Read completes with data this cycle |
| mem_rdata | input | DW | Read data |

## Verification
The assertions assume that memory answers only while mem_req is high and that mem_rdata belongs to the address presented in the ack cycle. The bench's memory model drives ack and data half a cycle after the address settles, with a random delay and at times long stalls. The wait-resolution property also assumes the load address is held while software waits. The random phase keeps addresses in a narrow window, so that prefetches overlap and retarget busy entries often, and the checks compare against a coverage model kept in the bench.

// File: rtl/pf_read_buf.sv
module pf_read_buf #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int NENT = 4,
  localparam int EW = $clog2(NENT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pf_valid,
  input  logic [EW-1:0] pf_slot,
  input  logic [AW-1:0] pf_addr,
  input  logic [1:0]    pf_len,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic          ld_wait,
  output logic [DW-1:0] ld_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int MAXW = 8;
  localparam int WW = $clog2(MAXW);

  function automatic logic [MAXW-1:0] span_mask(input logic [1:0] code);
    case (code)
      2'd0: return 8'h01;
      2'd1: return 8'h0F;
      2'd2: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [AW-1:0] span_len(input logic [1:0] code);
    case (code)
      2'd0: return AW'(1);
      2'd1: return AW'(4);
      2'd2: return AW'(8);
      default: return '0;
    endcase
  endfunction

  logic [AW-1:0]   base_q [NENT];
  logic [MAXW-1:0] cov_q  [NENT];
  logic [MAXW-1:0] got_q  [NENT];
  logic [DW-1:0]   dat_q  [NENT][MAXW];
  logic [MAXW-1:0] kill   [NENT];
  logic [AW-1:0]   loff   [NENT];
  logic [NENT-1:0] hitv, waitv;
  logic [DW-1:0]   ld_word;
  logic [EW-1:0]   sel_e;
  logic [WW-1:0]   sel_w;
  logic            any_pend;

  wire           pf_ok = pf_valid && (pf_len != 2'd3);
  wire [AW-1:0]  pf_n  = span_len(pf_len);
  wire           take  = mem_req && mem_ack;

  always_comb begin
    for (int e = 0; e < NENT; e++)
      for (int w = 0; w < MAXW; w++)
        kill[e][w] = pf_ok && (EW'(e) != pf_slot) &&
                     ((base_q[e] + AW'(w) - pf_addr) < pf_n);
  end

  always_comb begin
    any_pend = 1'b0;
    sel_e = '0;
    sel_w = '0;
    for (int e = NENT - 1; e >= 0; e--)
      if (|(cov_q[e] & ~got_q[e])) begin
        any_pend = 1'b1;
        sel_e = EW'(e);
      end
    for (int w = MAXW - 1; w >= 0; w--)
      if (cov_q[sel_e][w] && !got_q[sel_e][w]) sel_w = WW'(w);
  end

  assign mem_req  = any_pend;
  assign mem_addr = base_q[sel_e] + AW'(sel_w);

  always_comb begin
    ld_word = '0;
    for (int e = 0; e < NENT; e++) begin
      loff[e]  = ld_addr - base_q[e];
      hitv[e]  = ld_valid && (loff[e] < AW'(MAXW)) && cov_q[e][loff[e][WW-1:0]] &&
                 got_q[e][loff[e][WW-1:0]];
      waitv[e] = ld_valid && (loff[e] < AW'(MAXW)) && cov_q[e][loff[e][WW-1:0]] &&
                 !got_q[e][loff[e][WW-1:0]];
      if (hitv[e]) ld_word = dat_q[e][loff[e][WW-1:0]];
    end
  end

  assign ld_hit  = |hitv;
  assign ld_wait = |waitv;
  assign ld_data = ld_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NENT; e++) begin
        base_q[e] <= '0;
        cov_q[e]  <= '0;
        got_q[e]  <= '0;
      end
    end else begin
      for (int e = 0; e < NENT; e++) begin
        if (pf_ok && pf_slot == EW'(e)) begin
          base_q[e] <= pf_addr;
          cov_q[e]  <= span_mask(pf_len);
          got_q[e]  <= '0;
        end else begin
          cov_q[e] <= cov_q[e] & ~kill[e];
          if (take && sel_e == EW'(e)) got_q[e][sel_w] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) dat_q[sel_e][sel_w] <= mem_rdata;
  end
endmodule

// File: rtl/pf_read_buf_chk.sv
module pf_read_buf_chk #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int NENT = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pf_valid,
  input logic          ld_valid,
  input logic [AW-1:0] ld_addr,
  input logic          ld_hit,
  input logic          ld_wait,
  input logic [DW-1:0] ld_data,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] base_q [NENT],
  input logic [7:0]    cov_q  [NENT]
);
  function automatic logic holds(input logic [AW-1:0] b, input logic [7:0] c,
                                 input logic [AW-1:0] a);
    logic [AW-1:0] d;
    d = a - b;
    return (d < AW'(8)) && c[d[2:0]];
  endfunction

  logic [NENT-1:0] owners;
  always_comb
    for (int e = 0; e < NENT; e++) owners[e] = holds(base_q[e], cov_q[e], ld_addr);

  p_single_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owners));
  p_hit_wait_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit && ld_wait));
  p_owner_answer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> ((ld_hit || ld_wait) == (|owners)));
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> (!ld_hit && !ld_wait));
  p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_hit |-> (ld_data == '0));
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !pf_valid) |=> (mem_req && $stable(mem_addr)));
  p_wait_resolves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_wait && !pf_valid) |=>
      (!ld_valid || !$stable(ld_addr) || ld_hit || ld_wait));
endmodule

bind pf_read_buf pf_read_buf_chk #(.AW(AW), .DW(DW), .NENT(NENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .pf_valid(pf_valid), .ld_valid(ld_valid),
  .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_wait(ld_wait), .ld_data(ld_data),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .base_q(base_q), .cov_q(cov_q)
);

// File: tb/pf_read_buf_tb.sv
module pf_read_buf_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pf_valid = 1'b0;
  logic [1:0]  pf_slot = '0;
  logic [15:0] pf_addr = '0;
  logic [1:0]  pf_len = '0;
  logic        ld_valid = 1'b0;
  logic [15:0] ld_addr = '0;
  logic        ld_hit, ld_wait, mem_req;
  logic [31:0] ld_data;
  logic [15:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_en = 1'b1;
  logic [7:0]  gen = '0;
  int vecs = 0, fails = 0, cyc = 0;
  logic [15:0] mb [4];
  logic [7:0]  mc [4];

  pf_read_buf u_dut (.*);

  always #10 clk = ~clk;

  function automatic logic [31:0] mf(input logic [15:0] a, input logic [7:0] g);
    return {g, 8'h5A, a ^ 16'h3C3C};
  endfunction

  always @(negedge clk) begin
    #2;
    mem_ack   = mem_en && mem_req && ($urandom_range(0, 1) == 0);
    mem_rdata = mf(mem_addr, gen);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp<=150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic mcov(input logic [15:0] a);
    logic [15:0] d;
    for (int e = 0; e < 4; e++) begin
      d = a - mb[e];
      if (d < 16'd8 && mc[e][d[2:0]]) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic model_pf(input logic [1:0] s, input logic [15:0] a, input logic [1:0] l);
    logic [15:0] n;
    logic [15:0] d;
    if (l == 2'd3) return;
    n = (l == 2'd0) ? 16'd1 : (l == 2'd1) ? 16'd4 : 16'd8;
    for (int e = 0; e < 4; e++)
      if (e != s)
        for (int w = 0; w < 8; w++) begin
          d = mb[e] + 16'(w) - a;
          if (d < n) mc[e][w] = 1'b0;
        end
    mb[s] = a;
    mc[s] = (l == 2'd0) ? 8'h01 : (l == 2'd1) ? 8'h0F : 8'hFF;
  endtask

  task automatic do_pf(input logic [1:0] s, input logic [15:0] a, input logic [1:0] l);
    pf_valid = 1'b1; pf_slot = s; pf_addr = a; pf_len = l;
    @(posedge clk);
    model_pf(s, a, l);
    @(negedge clk);
    pf_valid = 1'b0;
  endtask

  task automatic look(input logic [15:0] a);
    ld_valid = 1'b1; ld_addr = a;
    #1;
  endtask

  task automatic settle();
    mem_en = 1'b1;
    repeat (100) tick();
  endtask

  task automatic check_model();
    #1;
    if (!ld_valid)
      chk(!ld_hit && !ld_wait, "R7 idle", {ld_hit, ld_wait}, 0);
    else if (mcov(ld_addr)) begin
      chk(ld_hit ^ ld_wait, "R6 covered", {ld_hit, ld_wait}, 1);
      if (ld_hit) chk(ld_data == mf(ld_addr, gen), "R5 data", ld_data, mf(ld_addr, gen));
    end else
      chk(!ld_hit && !ld_wait && ld_data == 0, "R7 miss", ld_data, 0);
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int e = 0; e < 4; e++) begin mb[e] = '0; mc[e] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    look(16'h0000);
    chk(!ld_hit && !ld_wait, "R1 reset lookup", {ld_hit, ld_wait}, 0);
    chk(!mem_req, "R1 reset mem_req", mem_req, 0);
    chk(ld_data == 0, "R7 miss data", ld_data, 0);

    mem_en = 1'b0;
    do_pf(2'd0, 16'h0010, 2'd1);
    chk(mem_req && mem_addr == 16'h0010, "R4 request", mem_addr, 16'h0010);
    tick();
    chk(mem_req && mem_addr == 16'h0010, "R4 hold", mem_addr, 16'h0010);
    look(16'h0013);
    chk(ld_wait && !ld_hit, "R6 pending", {ld_hit, ld_wait}, 1);
    look(16'h0014);
    chk(!ld_hit && !ld_wait, "R2 len4 end", {ld_hit, ld_wait}, 0);
    look(16'h0013);
    mem_en = 1'b1;
    for (int i = 0; i < 60 && !ld_hit; i++) begin tick(); #1; end
    chk(ld_hit && ld_data == mf(16'h0013, 0), "R6 resolves", ld_data, mf(16'h0013, 0));

    do_pf(2'd0, 16'h0040, 2'd3);
    settle();
    look(16'h0010);
    chk(ld_hit && ld_data == mf(16'h0010, 0), "R3 len3 ignored", ld_data, mf(16'h0010, 0));
    look(16'h0040);
    chk(!ld_hit && !ld_wait, "R3 no new range", {ld_hit, ld_wait}, 0);

    do_pf(2'd1, 16'h0020, 2'd0);
    do_pf(2'd2, 16'h0030, 2'd2);
    settle();
    look(16'h0020);
    chk(ld_hit, "R2 len1", ld_hit, 1);
    look(16'h0021);
    chk(!ld_hit && !ld_wait, "R2 len1 end", {ld_hit, ld_wait}, 0);
    look(16'h0037);
    chk(ld_hit && ld_data == mf(16'h0037, 0), "R2 len8", ld_data, mf(16'h0037, 0));
    look(16'h0038);
    chk(!ld_hit && !ld_wait, "R2 len8 end", {ld_hit, ld_wait}, 0);

    gen = 8'd1;
    look(16'h0030);
    chk(ld_hit && ld_data == mf(16'h0030, 0), "R10 stale kept", ld_data, mf(16'h0030, 0));

    do_pf(2'd3, 16'h0034, 2'd1);
    settle();
    look(16'h0035);
    chk(ld_hit && ld_data == mf(16'h0035, 1), "R8 new owner", ld_data, mf(16'h0035, 1));
    look(16'h0033);
    chk(ld_hit && ld_data == mf(16'h0033, 0), "R8 rest kept", ld_data, mf(16'h0033, 0));

    mem_en = 1'b0;
    do_pf(2'd2, 16'h0050, 2'd2);
    do_pf(2'd2, 16'h0060, 2'd0);
    settle();
    look(16'h0050);
    chk(!ld_hit && !ld_wait, "R9 old range gone", {ld_hit, ld_wait}, 0);
    look(16'h0060);
    chk(ld_hit && ld_data == mf(16'h0060, 1), "R9 new range", ld_data, mf(16'h0060, 1));
    look(16'h0031);
    chk(!ld_hit && !ld_wait, "R9 prior range gone", {ld_hit, ld_wait}, 0);
    chk(!mem_req, "R4 idle after fill", mem_req, 0);

    ld_valid = 1'b0;
    gen = 8'd2;
    rst_n = 1'b0;
    for (int e = 0; e < 4; e++) begin mb[e] = '0; mc[e] = '0; end
    tick();
    rst_n = 1'b1;
    tick();
    for (int i = 0; i < 3000; i++) begin
      logic pv;
      logic [1:0] s, l;
      logic [15:0] a;
      pv = ($urandom_range(0, 5) == 0);
      s = 2'($urandom_range(0, 3));
      l = 2'($urandom_range(0, 3));
      a = 16'($urandom_range(0, 31));
      pf_valid = pv; pf_slot = s; pf_addr = a; pf_len = l;
      ld_valid = ($urandom_range(0, 3) != 0);
      ld_addr = 16'($urandom_range(0, 39));
      mem_en = ($urandom_range(0, 7) != 0);
      check_model();
      @(posedge clk);
      if (pv) model_pf(s, a, l);
      @(negedge clk);
    end
    pf_valid = 1'b0;
    settle();
    for (int a = 0; a < 40; a++) begin
      look(16'(a));
      if (mcov(16'(a)))
        chk(ld_hit && ld_data == mf(16'(a), gen), "R5 filled", ld_data, mf(16'(a), gen));
      else
        chk(!ld_hit && !ld_wait, "R8 uncovered", {ld_hit, ld_wait}, 0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule